// File: doc/BRIEF.md
# Multi-Channel Repeat-Interval Interrupt Timer

This block holds several independent down-counting channels behind a single-cycle register bus. Software writes a non-zero interval V to a channel. The channel then counts V-1 down to zero and raises a sticky interrupt flag. It reloads V-1 and carries on, so the flag fires once every V clock cycles. Each channel drives its own interrupt line, which is the flag gated by a per-channel enable.

Every interval write carries a load flag in bit 31. With the flag clear, the new value is held as the pending reload, and the running countdown finishes first. With the flag set, the counter restarts from the new value at once. A zero interval stops the channel. If the stop is deferred, the channel first completes its countdown and raises its interrupt. If the stop is immediate, the channel goes idle at once and raises no interrupt.

Top module: `rpt_timer`

## Requirements
- R1: When an idle channel receives a non-zero interval V, its counter reads V-1 in the cycle after the write, and RUN (status bit 1) reads 1.
- R2: A running channel whose counter is non-zero decrements by one each cycle. At zero it sets its flag (status bit 0) and reloads V-1, so the flag sets every V cycles.
- R3: A non-zero write with bit 31 clear on a running channel leaves the current countdown unchanged. The countdown still ends with the flag, and the next period uses the new value.
- R4: A non-zero write with bit 31 set on a running channel makes the counter read new value minus one in the next cycle. The flag sets when that count reaches zero.
- R5: A zero write with bit 31 clear lets the current countdown finish. The channel sets its flag at zero, then RUN goes to 0 and the counter holds 0.
- R6: A zero write with bit 31 set clears RUN and the counter in the next cycle and does not set the flag, even when the counter is at zero in the cycle of the write.
- R7: The flag is sticky and is cleared by writing 1 to status bit 0. A flag being set in the same cycle wins over the clear. `irq_o[n]` is the flag of channel n ANDed with its enable (control bit 0).
- R8: Register map: `addr_i[3:2]` selects the channel and `addr_i[1:0]` selects the register. 0 is the interval (bits 23:0 hold the value, bit 31 is the load flag, and a read returns the pending value). 1 is the counter (read only). 2 is control (bit 0 is the enable). 3 is status (bit 0 is the flag, bit 1 is RUN). Reads are combinational.
- R9: Channels are independent. A write to one channel changes no other channel's counter, flag or interrupt.
- R10: After reset every channel is idle, and every register and interrupt line reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Channel and register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 4 | Per-channel interrupt lines |

## Verification
A write takes effect on the clock edge that samples it. The counter, RUN and pending value are readable half a cycle later, and the bench reads them at that falling edge. The flag and the interrupt line rise on the edge after the counter read 0. For an interval V written at edge k, that is edge k+V. Each task waits an exact number of falling edges computed from that rule, and samples the flag before and after its due edge. Immediate and deferred stops, and the zero-count collision with an immediate stop, are checked the same way.

// File: rtl/rpt_timer_pkg.sv
package rpt_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int LOAD_BIT = 31;

  typedef enum logic [1:0] {
    REG_IVAL  = 2'd0,
    REG_TIMER = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_e;
endpackage

// File: rtl/rpt_timer_chan.sv
module rpt_timer_chan #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ival_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_stat_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic             wr_load_i,
  input  logic             wr_bit0_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ival_o,
  output logic             run_o,
  output logic             flag_o,
  output logic             ie_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, ival_q, ival_d;
  logic             run_q, run_d, flag_q, flag_d, ie_q, set_flag;
  logic             val_nz, imm_wr;

  assign val_nz = |wr_val_i;
  assign imm_wr = wr_ival_i & wr_load_i;

  always_comb begin
    cnt_d    = cnt_q;
    ival_d   = ival_q;
    run_d    = run_q;
    set_flag = 1'b0;
    if (wr_ival_i) ival_d = wr_val_i;
    if (!run_q) begin
      if (wr_ival_i && val_nz) begin
        cnt_d = wr_val_i - ONE;
        run_d = 1'b1;
      end
    end else if (imm_wr) begin
      // immediate write overrides the tick, no interrupt
      if (val_nz) cnt_d = wr_val_i - ONE;
      else begin
        cnt_d = '0;
        run_d = 1'b0;
      end
    end else if (cnt_q == '0) begin
      set_flag = 1'b1;
      if (ival_d != '0) cnt_d = ival_d - ONE;
      else              run_d = 1'b0;
    end else begin
      cnt_d = cnt_q - ONE;
    end
    flag_d = set_flag | (flag_q & ~(wr_stat_i & wr_bit0_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ival_q <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ival_q <= ival_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      if (wr_ctrl_i) ie_q <= wr_bit0_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign ival_o = ival_q;
  assign run_o  = run_q;
  assign flag_o = flag_q;
  assign ie_o   = ie_q;

  AST_IDLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && wr_ival_i && val_nz |=> run_q && cnt_q == $past(wr_val_i) - ONE); // R1
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_q != '0 && !imm_wr |=> run_q && cnt_q == $past(cnt_q) - ONE); // R2
  AST_FLAG_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_q == '0 && !imm_wr |=> flag_q); // R2
  AST_IMM_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && imm_wr && val_nz |=> run_q && cnt_q == $past(wr_val_i) - ONE); // R4
  AST_DEFER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_q == '0 && ival_q == '0 && !wr_ival_i |=> !run_q && flag_q); // R5
  AST_IMM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_wr && !val_nz |=> !run_q && cnt_q == '0 && flag_q == $past(flag_q)); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && wr_bit0_i && !(run_q && cnt_q == '0) |=> !flag_q); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !wr_ival_i |=> !run_q && $stable(cnt_q)); // R9
endmodule

// File: rtl/rpt_timer_rdmux.sv
module rpt_timer_rdmux
  import rpt_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 24,
  parameter int CH_AW  = 2
) (
  input  logic [CH_AW-1:0]             ch_i,
  input  reg_e                         reg_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] ival_i,
  input  logic [NUM_CH-1:0]            run_i,
  input  logic [NUM_CH-1:0]            flag_i,
  input  logic [NUM_CH-1:0]            ie_i,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  always_comb begin
    rdata_o = '0;
    if (int'(ch_i) < NUM_CH) begin
      unique case (reg_i)
        REG_IVAL:  rdata_o = {{PAD_W{1'b0}}, ival_i[ch_i]};
        REG_TIMER: rdata_o = {{PAD_W{1'b0}}, cnt_i[ch_i]};
        REG_CTRL:  rdata_o = {{(DATA_W-1){1'b0}}, ie_i[ch_i]};
        REG_STAT:  rdata_o = {{(DATA_W-2){1'b0}}, run_i[ch_i], flag_i[ch_i]};
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rpt_timer.sv
module rpt_timer
  import rpt_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 24,
  localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = CH_AW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [CH_AW-1:0]             ch_sel;
  reg_e                         reg_sel;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt, ival;
  logic [NUM_CH-1:0]            run, flag, ie;
  logic                         unused_wdata;

  assign ch_sel       = addr_i[AW-1:2];
  assign reg_sel      = reg_e'(addr_i[1:0]);
  assign unused_wdata = ^wdata_i[LOAD_BIT-1:CNT_W];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en_i && (ch_sel == CH_AW'(g));

    rpt_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_ival_i (hit && reg_sel == REG_IVAL),
      .wr_ctrl_i (hit && reg_sel == REG_CTRL),
      .wr_stat_i (hit && reg_sel == REG_STAT),
      .wr_val_i  (wdata_i[CNT_W-1:0]),
      .wr_load_i (wdata_i[LOAD_BIT]),
      .wr_bit0_i (wdata_i[0]),
      .cnt_o     (cnt[g]),
      .ival_o    (ival[g]),
      .run_o     (run[g]),
      .flag_o    (flag[g]),
      .ie_o      (ie[g])
    );
  end

  assign irq_o = flag & ie;

  rpt_timer_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_AW(CH_AW)) u_rdmux (
    .ch_i    (ch_sel),
    .reg_i   (reg_sel),
    .cnt_i   (cnt),
    .ival_i  (ival),
    .run_i   (run),
    .flag_i  (flag),
    .ie_i    (ie),
    .rdata_o (rdata_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> irq_o == '0); // R10
  AST_OTHER_CH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && reg_sel == REG_CTRL && int'(ch_sel) < NUM_CH
      |=> (irq_o & ~(NUM_CH'(1) << $past(ch_sel))) >= ($past(irq_o) & ~(NUM_CH'(1) << $past(ch_sel)))); // R9
endmodule

// File: tb/rpt_timer_tb.sv
`timescale 1ns/1ps
module rpt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int checks = 0;
  int errors = 0;

  localparam int RI = 0, RT = 1, RC = 2, RS = 3;
  localparam logic [31:0] LD = 32'h8000_0000;

  always #5 clk = ~clk;

  rpt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; consumes exactly one rising edge
  task automatic wr(input int ch, input int rg, input logic [31:0] d);
    wr_en = 1'b1; addr = {2'(ch), 2'(rg)}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rchk(input string tag, input int ch, input int rg, input logic [31:0] exp);
    addr = {2'(ch), 2'(rg)};
    #0.1;
    chk(tag, rdata, exp);
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_all();
    for (int c = 0; c < 4; c++) wr(c, RS, 32'h1);
  endtask

  task automatic t_reset();
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) rchk("R10 reg after reset", c, r, 32'h0);
    chk("R10 irq after reset", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_repeat();
    wr(0, RC, 32'h1);
    rchk("R8 ctrl readback", 0, RC, 32'h1);
    wr(0, RI, 32'd5);
    rchk("R1 counter V-1", 0, RT, 32'd4);
    rchk("R1 run set", 0, RS, 32'h2);
    rchk("R8 interval readback", 0, RI, 32'd5);
    wt(4);
    rchk("R2 counter at zero", 0, RT, 32'd0);
    rchk("R2 no flag before due", 0, RS, 32'h2);
    wt(1);
    rchk("R2 flag at due edge", 0, RS, 32'h3);
    rchk("R2 reload", 0, RT, 32'd4);
    chk("R7 irq with enable", {28'h0, irq}, 32'h1);
    wr(0, RS, 32'h1);
    rchk("R7 flag cleared", 0, RS, 32'h2);
    chk("R7 irq low after clear", {28'h0, irq}, 32'h0);
    rchk("R2 still counting", 0, RT, 32'd3);
    wt(3);
    rchk("R2 second zero", 0, RS, 32'h2);
    wt(1);
    rchk("R2 second flag", 0, RS, 32'h3);
    wr(0, RI, LD);
    rchk("R6 stop clears run", 0, RS, 32'h1);
    rchk("R6 stop clears counter", 0, RT, 32'd0);
    clr_all();
  endtask

  task automatic t_deferred();
    wr(1, RI, 32'd6);
    wt(2);
    rchk("R3 pre count", 1, RT, 32'd3);
    wr(1, RI, 32'd3);
    rchk("R3 count unaffected", 1, RT, 32'd2);
    rchk("R3 pending value", 1, RI, 32'd3);
    wt(2);
    rchk("R3 old period no flag", 1, RS, 32'h2);
    wt(1);
    rchk("R3 old period flag", 1, RS, 32'h3);
    rchk("R3 new reload", 1, RT, 32'd2);
    wr(1, RS, 32'h1);
    wt(2);
    rchk("R3 new period flag", 1, RS, 32'h3);
    rchk("R3 new period reload", 1, RT, 32'd2);
    wr(1, RI, LD);
    clr_all();
  endtask

  task automatic t_immediate();
    wr(2, RI, 32'd10);
    wt(3);
    rchk("R4 pre count", 2, RT, 32'd6);
    wr(2, RI, LD | 32'd4);
    rchk("R4 restart", 2, RT, 32'd3);
    rchk("R4 no flag on write", 2, RS, 32'h2);
    wt(3);
    rchk("R4 zero no flag", 2, RS, 32'h2);
    wt(1);
    rchk("R4 flag", 2, RS, 32'h3);
    rchk("R4 reload new", 2, RT, 32'd3);
    wr(2, RI, LD);
    clr_all();
  endtask

  task automatic t_defer_stop();
    wr(3, RI, 32'd4);
    wt(1);
    wr(3, RI, 32'd0);
    rchk("R5 still running", 3, RS, 32'h2);
    rchk("R5 count continues", 3, RT, 32'd1);
    wt(1);
    rchk("R5 at zero", 3, RT, 32'd0);
    wt(1);
    rchk("R5 flag then idle", 3, RS, 32'h1);
    wt(3);
    rchk("R5 stays idle", 3, RS, 32'h1);
    rchk("R5 counter held", 3, RT, 32'd0);
    clr_all();
  endtask

  task automatic t_imm_stop();
    wr(3, RC, 32'h1);
    wr(3, RI, 32'd3);
    wt(1);
    wr(3, RI, LD);
    rchk("R6 idle at once", 3, RS, 32'h0);
    wt(5);
    rchk("R6 no later flag", 3, RS, 32'h0);
    wr(3, RI, 32'd2);
    wt(1);
    rchk("R6 at zero", 3, RT, 32'd0);
    wr(3, RI, LD);
    rchk("R6 stop at zero no flag", 3, RS, 32'h0);
    wt(2);
    chk("R6 irq quiet", {28'h0, irq}, 32'h0);
    wr(3, RC, 32'h0);
  endtask

  task automatic t_indep();
    wr(1, RC, 32'h1);
    wr(0, RI, 32'd3);
    wr(1, RI, 32'd5);
    rchk("R9 ch1 count", 1, RT, 32'd4);
    rchk("R9 ch0 count", 0, RT, 32'd1);
    wt(2);
    chk("R9 only ch0 irq", {28'h0, irq}, 32'h1);
    rchk("R9 ch1 unaffected", 1, RT, 32'd2);
    wt(3);
    chk("R9 both irq", {28'h0, irq}, 32'h3);
    wr(0, RI, LD);
    wr(1, RI, LD);
    wr(0, RS, 32'h1);
    chk("R9 clear ch0 leaves ch1", {28'h0, irq}, 32'h2);
    clr_all();
    wr(1, RC, 32'h0);
  endtask

  task automatic t_mask();
    wr(2, RI, 32'd1);
    rchk("R1 V=1 count", 2, RT, 32'd0);
    wt(1);
    rchk("R7 flag set masked", 2, RS, 32'h3);
    chk("R7 irq masked", {28'h0, irq}, 32'h0);
    wr(2, RC, 32'h1);
    chk("R7 irq unmasked", {28'h0, irq}, 32'h4);
    wr(2, RS, 32'h1);
    rchk("R7 set wins over clear", 2, RS, 32'h3);
    wr(2, RI, LD);
    clr_all();
    chk("R7 irq after stop and clear", {28'h0, irq}, 32'h0);
    wr(2, RC, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wt(3);
    rst_n = 1'b1;
    wt(1);
    t_reset();
    t_repeat();
    t_deferred();
    t_immediate();
    t_defer_stop();
    t_imm_stop();
    t_indep();
    t_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule